// File: doc/BRIEF.md
# Algorithmic Sector Erase Sequencer

This block sits on the host side of a flash command bus and erases one sector using erase pulses that grow longer after each failed check. A one-cycle `start` pulse latches the sector number. The block then runs the following loop:

1. Write the erase setup byte.
2. Write the erase execute byte.
3. Let the pulse run for a counted number of clock cycles.
4. Write the Reset byte to stop the pulse.
5. Write the erase-verify command.
6. Read the sector bytes in ascending order and check each one for the erased value `0xFF`.

A byte that is not `0xFF` ends the verify pass at once. The next pulse is then twice as long. After `DOUBLINGS` pulses the length stops growing, and up to `MAX_RETRIES` further pulses run at the maximum length. When every pulse is used and no verify pass has succeeded, the block pulses `fail`. When a verify pass succeeds, it pulses `done`. In both cases `iter_count` holds the number of pulses issued.

The bus side is one request channel and one response input.

- **Request channel.** It uses valid/ready. Once `req_valid` is high, it stays high, and the address, data and direction stay fixed, until a cycle in which `req_ready` is high. That cycle completes the transfer. `req_valid` never depends on `req_ready` in the same cycle, so the bus may apply back-pressure for as long as it likes.
- **Response input.** `rsp_valid` carries one byte per read. The block accepts it only while it is waiting for a read that has already been accepted. It cannot stall a response.

Top module: `sector_erase_seq`

## Requirements
- R1: After `start` in idle, the block writes `0x22` and then `0xDD`. Both writes have `req_write`=1 and go to address {sector, zero offset}, where the sector field is the upper `SECT_W` bits of `req_addr`.
- R2: For pulse k (counting from 1), the Reset write `0xFF` first shows valid P(k)+1 cycles after the cycle in which the execute write was accepted. P(k) = `BASE_CYC` << min(k-1, `DOUBLINGS`-1).
- R3: The Reset write is never presented before at least `BASE_CYC` cycles of erase time have passed since the execute write was accepted.
- R4: After Reset is accepted, the block writes `0xAA` to the sector base address. It then issues reads (`req_write`=0) at offsets 0, 1, 2 and so on, one at a time, each after the previous response. The first response that is not `0xFF` ends the pass without any further read.
- R5: When all `SECTOR_BYTES` responses are `0xFF`, `done` is high for exactly one cycle and `iter_count` equals the number of pulses issued. After that, `busy` is low.
- R6: Each failed verify pass below the limit starts a new pulse (`0x22`, `0xDD`). From pulse `DOUBLINGS` onward, the pulse length stays at `BASE_CYC` << (`DOUBLINGS`-1).
- R7: If pulse number `DOUBLINGS`+`MAX_RETRIES` also fails verify, `fail` is high for one cycle, `iter_count` equals `DOUBLINGS`+`MAX_RETRIES`, no further request is made, and `done` is not raised.
- R8: While `busy` is high, `start` and changes on `sector` have no effect on the request stream or the outcome.
- R9: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high with the same `req_addr`, `req_wdata` and `req_write`.
- R10: During and after reset, `busy`, `done`, `fail` and `req_valid` are low and `iter_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Erase request, sampled only when idle |
| sector | input | SECT_W | Sector number, latched with start |
| busy | output | 1 | High from start until the cycle after done or fail |
| done | output | 1 | One-cycle pulse: verify passed |
| fail | output | 1 | One-cycle pulse: pulse budget used without a pass |
| iter_count | output | $clog2(DOUBLINGS+MAX_RETRIES+1) | Pulses issued in the current or last run |
| req_valid | output | 1 | Request channel valid |
| req_ready | input | 1 | Request channel ready |
| req_write | output | 1 | 1 = command write, 0 = read |
| req_addr | output | SECT_W+$clog2(SECTOR_BYTES) | {sector, byte offset} |
| req_wdata | output | 8 | Command byte for writes |
| rsp_valid | input | 1 | Read data valid, one cycle per accepted read |
| rsp_data | input | 8 | Read data |

## Verification
The assertions assume three things about the inputs:

- `rsp_valid` rises only after a read has been accepted, and only once per read.
- `BASE_CYC` is at least one.
- `req_ready` may do anything.

The bench stub meets these assumptions. It answers each accepted read with a single-cycle response after a random delay of one to three cycles. It drives `req_ready` either always high or at random. It sets the pass or failure of each verify pass from a per-run target pulse count, placing the failing byte at a random offset. Some runs also toggle `start` and `sector` while the block is busy.

// File: rtl/ses_pkg.sv
`timescale 1ns/1ps
package ses_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_EXEC, ST_PULSE, ST_ABORT,
    ST_EVCMD, ST_RDREQ, ST_RDWAIT, ST_DONE, ST_FAIL
  } ses_state_e;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h22;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hDD;
  localparam logic [7:0] CMD_ABORT       = 8'hFF;
  localparam logic [7:0] CMD_EVERIFY     = 8'hAA;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;
endpackage

// File: rtl/ses_pulse_timer.sv
`timescale 1ns/1ps
module ses_pulse_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] len,
  input  logic             run,
  output logic             last,
  output logic [TMR_W-1:0] elapsed
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      len_q <= len;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last    = run && (cnt_q == len_q - 1'b1);
  assign elapsed = cnt_q;

  // R2: a running pulse never overshoots its programmed length
  a_r2_within_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < len_q));
  // R2: a loaded pulse always has a non-zero length
  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));
endmodule

// File: rtl/ses_iter_tracker.sv
`timescale 1ns/1ps
module ses_iter_tracker #(
  parameter int BASE_CYC    = 5000,
  parameter int DOUBLINGS   = 7,
  parameter int MAX_RETRIES = 150,
  parameter int TMR_W       = 16,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [TMR_W-1:0] pulse_len,
  output logic [CNT_W-1:0] iter_count,
  output logic             exhausted
);
  localparam int TOTAL   = DOUBLINGS + MAX_RETRIES;
  localparam int SH_W    = $clog2(DOUBLINGS + 1);
  localparam int SH_MAX  = DOUBLINGS - 1;
  localparam int MAX_LEN = BASE_CYC * (1 << (DOUBLINGS - 1));

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] iter_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      iter_q <= '0;
    end else if (clear) begin
      sh_q   <= '0;
      iter_q <= '0;
    end else if (bump) begin
      if (iter_q != CNT_W'(TOTAL)) iter_q <= iter_q + 1'b1;
      if (sh_q != SH_W'(SH_MAX))   sh_q   <= sh_q + 1'b1;
    end
  end

  assign pulse_len  = TMR_W'(BASE_CYC) << sh_q;
  assign iter_count = iter_q;
  assign exhausted  = (iter_q == CNT_W'(TOTAL));

  // R6: the pulse length never grows past the capped maximum
  a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_len <= TMR_W'(MAX_LEN));
  // R7: the pulse count never exceeds the budget
  a_r7_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= CNT_W'(TOTAL));
endmodule

// File: rtl/ses_verify_scan.sv
`timescale 1ns/1ps
module ses_verify_scan #(
  parameter int SECTOR_BYTES = 256,
  parameter int BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [BYTE_W-1:0] offset,
  output logic              last
);
  logic [BYTE_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       off_q <= '0;
    else if (clear)   off_q <= '0;
    else if (advance) off_q <= off_q + 1'b1;
  end

  assign offset = off_q;
  assign last   = (off_q == BYTE_W'(SECTOR_BYTES - 1));

  // R4: the scan stays inside the sector
  a_r4_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= BYTE_W'(SECTOR_BYTES - 1));
  // R4: the controller never advances past the last byte
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !last);
endmodule

// File: rtl/sector_erase_seq.sv
`timescale 1ns/1ps
module sector_erase_seq
  import ses_pkg::*;
#(
  parameter int BASE_CYC     = 5000,
  parameter int DOUBLINGS    = 7,
  parameter int MAX_RETRIES  = 150,
  parameter int SECTOR_BYTES = 256,
  parameter int SECT_W       = 11,
  localparam int TOTAL  = DOUBLINGS + MAX_RETRIES,
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int BYTE_W = $clog2(SECTOR_BYTES),
  localparam int ADDR_W = SECT_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] sector,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  iter_count,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data
);
  localparam int MAX_LEN = BASE_CYC * (1 << (DOUBLINGS - 1));
  localparam int TMR_W   = $clog2(MAX_LEN + 1) + 1;

  ses_state_e        state_q, state_d;
  logic [SECT_W-1:0] sector_q;

  logic              tr_clear, tr_bump, tr_exhausted;
  logic [TMR_W-1:0]  tr_len;
  logic              tmr_load, tmr_run, tmr_last;
  logic [TMR_W-1:0]  tmr_elapsed;
  logic              sc_clear, sc_adv, sc_last;
  logic [BYTE_W-1:0] sc_off;
  logic              rsp_erased;

  assign rsp_erased = (rsp_data == ERASED_BYTE);

  ses_iter_tracker #(
    .BASE_CYC(BASE_CYC), .DOUBLINGS(DOUBLINGS), .MAX_RETRIES(MAX_RETRIES),
    .TMR_W(TMR_W), .CNT_W(CNT_W)
  ) u_iter (
    .clk(clk), .rst_n(rst_n), .clear(tr_clear), .bump(tr_bump),
    .pulse_len(tr_len), .iter_count(iter_count), .exhausted(tr_exhausted)
  );

  ses_pulse_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tr_len), .run(tmr_run),
    .last(tmr_last), .elapsed(tmr_elapsed)
  );

  ses_verify_scan #(.SECTOR_BYTES(SECTOR_BYTES), .BYTE_W(BYTE_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .clear(sc_clear), .advance(sc_adv),
    .offset(sc_off), .last(sc_last)
  );

  // sequencing control
  assign tr_clear = (state_q == ST_IDLE) && start;
  assign tr_bump  = (state_q == ST_EXEC) && req_ready;
  assign tmr_load = tr_bump;
  assign tmr_run  = (state_q == ST_PULSE);
  assign sc_clear = (state_q == ST_EVCMD) && req_ready;
  assign sc_adv   = (state_q == ST_RDWAIT) && rsp_valid && rsp_erased && !sc_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start)     state_d = ST_SETUP;
      ST_SETUP:  if (req_ready) state_d = ST_EXEC;
      ST_EXEC:   if (req_ready) state_d = ST_PULSE;
      ST_PULSE:  if (tmr_last)  state_d = ST_ABORT;
      ST_ABORT:  if (req_ready) state_d = ST_EVCMD;
      ST_EVCMD:  if (req_ready) state_d = ST_RDREQ;
      ST_RDREQ:  if (req_ready) state_d = ST_RDWAIT;
      ST_RDWAIT: begin
        if (rsp_valid) begin
          if (!rsp_erased)  state_d = tr_exhausted ? ST_FAIL : ST_SETUP;
          else if (sc_last) state_d = ST_DONE;
          else              state_d = ST_RDREQ;
        end
      end
      ST_DONE:   state_d = ST_IDLE;
      ST_FAIL:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sector_q <= '0;
    end else begin
      state_q <= state_d;
      if (tr_clear) sector_q <= sector;
    end
  end

  // request channel, driven from registered state only
  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b1;
    req_wdata = 8'h00;
    req_addr  = {sector_q, {BYTE_W{1'b0}}};
    unique case (state_q)
      ST_SETUP: begin req_valid = 1'b1; req_wdata = CMD_ERASE_SETUP; end
      ST_EXEC:  begin req_valid = 1'b1; req_wdata = CMD_ERASE_GO;    end
      ST_ABORT: begin req_valid = 1'b1; req_wdata = CMD_ABORT;       end
      ST_EVCMD: begin req_valid = 1'b1; req_wdata = CMD_EVERIFY;     end
      ST_RDREQ: begin
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = {sector_q, sc_off};
      end
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);
  assign fail = (state_q == ST_FAIL);

  // R9: request fields hold under back-pressure
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write)));
  // R3: Reset command only after the minimum erase time
  a_r3_min_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_wdata == CMD_ABORT) |-> (tmr_elapsed >= TMR_W'(BASE_CYC)));
  // R5: done is a single-cycle pulse followed by idle
  a_r5_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R7: fail reports the full budget and never coincides with done
  a_r7_fail_count: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (iter_count == CNT_W'(TOTAL) && !done));
  // R8: start while busy does not move the addressed sector
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(req_addr[ADDR_W-1:BYTE_W]));
endmodule

// File: tb/tb_sector_erase_seq.sv
`timescale 1ns/1ps
module tb_sector_erase_seq;
  localparam int BASE = 3;
  localparam int DBL  = 7;
  localparam int RETR = 150;
  localparam int SB   = 8;
  localparam int SW   = 6;
  localparam int TOT  = DBL + RETR;
  localparam int BW   = $clog2(SB);
  localparam int AW   = SW + BW;
  localparam int CW   = $clog2(TOT + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] sector = '0;
  logic          busy, done, fail;
  logic [CW-1:0] iter_count;
  logic          req_valid, req_write;
  logic          req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_wdata;
  logic          rsp_valid = 1'b0;
  logic [7:0]    rsp_data = 8'h00;

  sector_erase_seq #(
    .BASE_CYC(BASE), .DOUBLINGS(DBL), .MAX_RETRIES(RETR),
    .SECTOR_BYTES(SB), .SECT_W(SW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sector(sector),
    .busy(busy), .done(done), .fail(fail), .iter_count(iter_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit timeout = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) timeout = 1;
  end

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic int exp_len(int p);
    int s;
    s = (p - 1 < DBL - 1) ? p - 1 : DBL - 1;
    return BASE << s;
  endfunction

  // flash stub and monitor state
  int          need = 1;
  int          pulses = 0;
  int          phase = 0;
  int          rd_off = 0;
  int          fail_off = 0;
  int          rsp_cnt = 0;
  logic [7:0]  rsp_next = 8'hFF;
  bit          rand_rdy = 0;
  bit          wait_abort = 0;
  int          exec_cyc = 0;
  bit          done_seen = 0;
  bit          fail_seen = 0;
  int          done_cnt = 0;
  int          iter_at_end = 0;
  logic [SW-1:0] cur_sector = '0;
  bit          prev_stall = 0;
  logic [AW-1:0] p_addr = '0;
  logic [7:0]  p_wd = '0;
  logic        p_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      // response delivery
      rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = rsp_next;
        end
      end
      // R9: fields held while stalled
      if (prev_stall)
        chk(req_valid && req_addr == p_addr && req_wdata == p_wd && req_write == p_wr,
            "R9 request held", int'(req_wdata), int'(p_wd));
      if (done) begin done_seen = 1; done_cnt++; iter_at_end = int'(iter_count); end
      if (fail) begin fail_seen = 1; iter_at_end = int'(iter_count); end
      // R2/R3/R6: pulse length
      if (wait_abort && req_valid && req_write && req_wdata == 8'hFF) begin
        chk(cyc - exec_cyc == exp_len(pulses) + 1,
            pulses > DBL ? "R6 capped pulse length" : "R2 pulse length",
            cyc - exec_cyc, exp_len(pulses) + 1);
        chk(cyc - exec_cyc >= BASE + 1, "R3 minimum erase time", cyc - exec_cyc, BASE + 1);
        wait_abort = 0;
      end
      // ready for the coming edge
      req_ready = rand_rdy ? ($urandom % 3 != 0) : 1'b1;
      prev_stall = req_valid && !req_ready;
      p_addr = req_addr; p_wd = req_wdata; p_wr = req_write;
      if (req_valid && req_ready) begin
        if (req_write) begin
          chk(req_addr == {cur_sector, BW'(0)}, "R1 command address (R8 sector kept)",
              int'(req_addr), int'({cur_sector, BW'(0)}));
          case (phase)
            0: begin chk(req_wdata == 8'h22, "R1 setup byte (R6 retry)", int'(req_wdata), 'h22); phase = 1; end
            1: begin
              chk(req_wdata == 8'hDD, "R1 execute byte", int'(req_wdata), 'hDD);
              phase = 2; pulses++; exec_cyc = cyc; wait_abort = 1;
              fail_off = int'($urandom % SB);
            end
            2: begin chk(req_wdata == 8'hFF, "R2 reset byte", int'(req_wdata), 'hFF); phase = 3; end
            3: begin chk(req_wdata == 8'hAA, "R4 verify command", int'(req_wdata), 'hAA); phase = 4; rd_off = 0; end
            default: chk(0, "R4/R7 unexpected write", int'(req_wdata), phase);
          endcase
        end else begin
          chk(phase == 4 && req_addr == {cur_sector, BW'(rd_off)}, "R4 read order",
              int'(req_addr), int'({cur_sector, BW'(rd_off)}));
          if (pulses < need && rd_off == fail_off)
            rsp_next = 8'hFF ^ (8'h01 << ($urandom % 8));
          else
            rsp_next = 8'hFF;
          rsp_cnt = 1 + int'($urandom % 3);
          if (rsp_next != 8'hFF)  phase = 0;
          else if (rd_off == SB - 1) phase = 5;
          else rd_off++;
        end
      end
    end
  end

  task automatic run_case(int n, bit rr, bit noise);
    int exp_it;
    @(negedge clk);
    need = n; pulses = 0; phase = 0; done_seen = 0; fail_seen = 0; done_cnt = 0;
    rand_rdy = rr; wait_abort = 0;
    cur_sector = SW'($urandom);
    sector = cur_sector;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sector = SW'($urandom);
    while (!done_seen && !fail_seen && !timeout) begin
      @(negedge clk);
      start = noise && busy && ($urandom % 6 == 0);
      if (noise) sector = SW'($urandom);
    end
    start = 1'b0;
    exp_it = (n <= TOT) ? n : TOT;
    if (n <= TOT) begin
      chk(done_seen && !fail_seen, noise ? "R8 outcome with start noise" : "R5 done raised",
          int'(done_seen), 1);
    end else begin
      chk(fail_seen && !done_seen, "R7 fail raised", int'(fail_seen), 1);
      chk(pulses == TOT, "R7 pulse budget", pulses, TOT);
    end
    chk(iter_at_end == exp_it, n <= TOT ? "R5 iteration count" : "R7 iteration count",
        iter_at_end, exp_it);
    repeat (4) @(negedge clk);
    chk(!busy && !req_valid, "R5 idle afterwards", int'(busy), 0);
    chk(done_cnt <= 1, "R5 single done pulse", done_cnt, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !fail && !req_valid, "R10 outputs low in reset",
        int'({busy, done, fail, req_valid}), 0);
    chk(iter_count == '0, "R10 iter_count zero", int'(iter_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid, "R10 idle after reset", int'(busy), 0);

    // directed corner cases
    if (!timeout) run_case(1, 0, 0);
    if (!timeout) run_case(2, 1, 0);
    if (!timeout) run_case(DBL, 0, 0);
    if (!timeout) run_case(DBL + 1, 1, 0);
    if (!timeout) run_case(5, 0, 1);
    if (!timeout) run_case(TOT, 0, 0);
    if (!timeout) run_case(TOT + 50, 1, 0);
    // random mix
    for (int i = 0; i < 8; i++)
      if (!timeout) run_case(1 + int'($urandom % 12), $urandom % 2 == 1, $urandom % 2 == 1);

    if (timeout) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule